// File: doc/BRIEF.md
# PWM Fault Latch with Single-Channel Restart

This block generates two pulse-width-modulated outputs, A and B, from one shared period counter. Each output has its own duty value and both begin their high phase together at the start of every period. A digital fault level, already qualified by an external comparator stage, shuts output B down. The shutdown is latched: B stays off after the fault goes away until software releases it.

Software releases the latch in one of two ways. The first is a 0-to-1 transition of a restart control bit that hardware never clears. This re-arms output B alone, and output A keeps running without a glitch. The second is to switch the whole PWM off and on again. After a restart edge, B is held off until the next period start, so it never emits a shortened pulse.

A sticky fault interrupt flag, gated by its own enable, reports the fault without taking part in the shutdown. A sticky period flag marks each period start. That flag cannot be cleared while the PWM is disabled and its enable is still set, so software must drop the period enable before disabling the PWM.

Top module: `pfl_top`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `pwm_a`, `pwm_b`, `flt_irq` and `per_irq` are 0.
- R2: With `pwm_en` high, the counter runs from 0 to `period` and wraps, so one period lasts `period`+1 cycles. `pwm_a` is high for the first `duty_a` cycles of each period and `pwm_b` for the first `duty_b` cycles. Output registers lag the counter by one cycle.
- R3: `fault_in` high forces `pwm_b` low no later than the third rising clock edge after it is sampled (two synchronizer flops plus the output register), whatever the value of `flt_irq_en`.
- R4: Once shut down, `pwm_b` stays low after `fault_in` returns to 0. Nothing releases it automatically.
- R5: Only a 0-to-1 transition of `restart_ctl` releases the latch. Holding `restart_ctl` at 1 has no effect, and hardware never clears the bit, so it must return to 0 before another release can occur.
- R6: A restart edge that arrives while the synchronized fault is still high is ignored, and the latch stays set.
- R7: After a release, `pwm_b` resumes at the next period start: its first high cycle coincides with the rising edge of `pwm_a` (given a nonzero `duty_a`).
- R8: Faults, releases and restart writes never alter `pwm_a`.
- R9: `flt_irq` is set while the synchronized fault is high and `flt_irq_en` is 1, and is never set when `flt_irq_en` is 0. It stays set until a cycle with `flt_irq_clr` high and no set condition.
- R10: With `pwm_en` low, both outputs are low, the counter is held at 0 and the fault latch is cleared. After re-enabling, B runs normally when no fault is present.
- R11: `per_irq` is set on each cycle the counter is 0 while `per_irq_en` is 1, and is cleared by `per_irq_clr` otherwise. While `pwm_en` is low and `per_irq_en` is 1 it therefore stays at 1 whatever is written to the clear bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pwm_en | input | 1 | Runs the PWM; low holds the counter at 0 and clears the fault latch |
| period | input | CNT_W | Last count of the period (period length = value + 1) |
| duty_a | input | CNT_W | High-time of output A, in cycles |
| duty_b | input | CNT_W | High-time of output B, in cycles |
| fault_in | input | 1 | Asynchronous fault level, active high |
| flt_irq_en | input | 1 | Fault interrupt enable |
| flt_irq_clr | input | 1 | Write-1 clear of the fault interrupt flag |
| restart_ctl | input | 1 | Restart control bit; its rising edge releases the B latch |
| per_irq_en | input | 1 | Period interrupt enable |
| per_irq_clr | input | 1 | Write-1 clear of the period interrupt flag |
| pwm_a | output | 1 | PWM output A |
| pwm_b | output | 1 | PWM output B, subject to the fault latch |
| flt_irq | output | 1 | Sticky fault interrupt flag |
| per_irq | output | 1 | Sticky period interrupt flag |

## Verification
The fault is applied first with its interrupt disabled and then with it enabled. This separates the shutdown path from the interrupt path. The restart bit is exercised in three ways: a level held high since before the fault, an edge raised while the fault is still present, and a clean edge after the fault has cleared. Together these distinguish edge detection from level sensing and show that a present fault takes priority over a release. Output A is compared on every cycle of every phase, so any coupling from the B latch shows up, and the first B pulse after release is checked for alignment with A's period start. A disable/enable cycle and a period-flag clear attempted while the PWM is off cover the fallback release and the stuck period flag.

// File: rtl/pfl_pkg.sv
package pfl_pkg;
  typedef enum logic [1:0] {
    ST_RUN    = 2'd0,
    ST_LOCKED = 2'd1,
    ST_ARMED  = 2'd2
  } lock_state_t;
endpackage

// File: rtl/pfl_sync.sv
module pfl_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sr;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) sr[0] <= 1'b0;
        else     sr[0] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) sr[i] <= 1'b0;
        else     sr[i] <= sr[i-1];
      end
    end
  end

  assign q = sr[STAGES-1];
endmodule

// File: rtl/pfl_rise_det.sv
module pfl_rise_det (
  input  logic clk,
  input  logic rst,
  input  logic lvl,
  output logic pulse
);
  logic lvl_q, lvl_prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      lvl_q    <= 1'b0;
      lvl_prev <= 1'b0;
    end else begin
      lvl_q    <= lvl;
      lvl_prev <= lvl_q;
    end
  end

  assign pulse = lvl_q & ~lvl_prev;

  // R5: a level held high yields a single pulse, never two in a row
  p_single_pulse_r5: assert property (@(posedge clk) disable iff (rst)
    pulse |=> !pulse);
endmodule

// File: rtl/pfl_period_ctr.sv
module pfl_period_ctr #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [CNT_W-1:0] period,
  output logic [CNT_W-1:0] cnt,
  output logic             at_start,
  output logic             at_wrap
);
  always_ff @(posedge clk) begin
    if (rst || !en)       cnt <= '0;
    else if (cnt >= period) cnt <= '0;
    else                  cnt <= cnt + 1'b1;
  end

  assign at_start = (cnt == '0);
  assign at_wrap  = en && (cnt >= period);

  // R10: disabled counter sits at zero
  p_hold_zero_r10: assert property (@(posedge clk) disable iff (rst)
    !en |=> at_start);
endmodule

// File: rtl/pfl_fault_lock.sv
module pfl_fault_lock
  import pfl_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        en,
  input  logic        fault_s,
  input  logic        restart_p,
  input  logic        wrap,
  output lock_state_t state,
  output logic        b_allow
);
  always_ff @(posedge clk) begin
    if (rst || !en) begin
      state <= ST_RUN;
    end else if (fault_s) begin
      state <= ST_LOCKED;
    end else begin
      unique case (state)
        ST_LOCKED: if (restart_p) state <= ST_ARMED;
        ST_ARMED:  if (wrap)      state <= ST_RUN;
        default:                  state <= ST_RUN;
      endcase
    end
  end

  assign b_allow = (state == ST_RUN) && !fault_s;

  // R3: a synchronized fault always lands in the locked state
  p_lock_on_fault_r3: assert property (@(posedge clk) disable iff (rst)
    (en && fault_s) |=> (state == ST_LOCKED));
  // R4: locked state persists without a restart pulse
  p_latch_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (en && state == ST_LOCKED && !restart_p) |=> (state == ST_LOCKED));
  // R7: armed state waits for the period boundary
  p_wait_boundary_r7: assert property (@(posedge clk) disable iff (rst)
    (en && state == ST_ARMED && !fault_s && !wrap) |=> (state == ST_ARMED));
endmodule

// File: rtl/pfl_top.sv
module pfl_top
  import pfl_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pwm_en,
  input  logic [CNT_W-1:0] period,
  input  logic [CNT_W-1:0] duty_a,
  input  logic [CNT_W-1:0] duty_b,
  input  logic             fault_in,
  input  logic             flt_irq_en,
  input  logic             flt_irq_clr,
  input  logic             restart_ctl,
  input  logic             per_irq_en,
  input  logic             per_irq_clr,
  output logic             pwm_a,
  output logic             pwm_b,
  output logic             flt_irq,
  output logic             per_irq
);
  logic             fault_s, restart_p, at_start, at_wrap, b_allow;
  logic [CNT_W-1:0] cnt;
  lock_state_t      lk_state;

  pfl_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d(fault_in), .q(fault_s));

  pfl_rise_det u_rise (
    .clk(clk), .rst(rst), .lvl(restart_ctl), .pulse(restart_p));

  pfl_period_ctr #(.CNT_W(CNT_W)) u_ctr (
    .clk(clk), .rst(rst), .en(pwm_en), .period(period),
    .cnt(cnt), .at_start(at_start), .at_wrap(at_wrap));

  pfl_fault_lock u_lock (
    .clk(clk), .rst(rst), .en(pwm_en), .fault_s(fault_s),
    .restart_p(restart_p), .wrap(at_wrap),
    .state(lk_state), .b_allow(b_allow));

  always_ff @(posedge clk) begin
    if (rst) begin
      pwm_a   <= 1'b0;
      pwm_b   <= 1'b0;
      flt_irq <= 1'b0;
      per_irq <= 1'b0;
    end else begin
      pwm_a <= pwm_en && (cnt < duty_a);
      pwm_b <= pwm_en && b_allow && (cnt < duty_b);
      if (fault_s && flt_irq_en)  flt_irq <= 1'b1;
      else if (flt_irq_clr)       flt_irq <= 1'b0;
      if (per_irq_en && at_start) per_irq <= 1'b1;
      else if (per_irq_clr)       per_irq <= 1'b0;
    end
  end

  // R3: any non-running latch state keeps B low on the next cycle
  p_b_off_r3: assert property (@(posedge clk) disable iff (rst)
    (lk_state != ST_RUN) |=> !pwm_b);
  // R9: the fault flag holds until cleared
  p_flt_sticky_r9: assert property (@(posedge clk) disable iff (rst)
    (flt_irq && !flt_irq_clr) |=> flt_irq);
  // R9: with the enable off the flag never rises
  p_flt_gated_r9: assert property (@(posedge clk) disable iff (rst)
    (!flt_irq && !flt_irq_en) |=> !flt_irq);
  // R10: disabled PWM drives both outputs low
  p_disable_low_r10: assert property (@(posedge clk) disable iff (rst)
    !pwm_en |=> (!pwm_a && !pwm_b));
  // R11: period flag stuck while disabled with its enable set
  p_per_stuck_r11: assert property (@(posedge clk) disable iff (rst)
    (!pwm_en && $past(!pwm_en) && per_irq_en) |=> per_irq);
endmodule

// File: tb/tb_pfl_top.sv
`timescale 1ns/1ps
module tb_pfl_top;
  localparam int W = 8;

  logic clk = 1'b0, rst = 1'b1;
  logic pwm_en = 0, fault_in = 0, flt_irq_en = 0, flt_irq_clr = 0;
  logic restart_ctl = 0, per_irq_en = 0, per_irq_clr = 0;
  logic [W-1:0] period = 9, duty_a = 4, duty_b = 6;
  logic pwm_a, pwm_b, flt_irq, per_irq;

  int checks = 0, fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  pfl_top #(.CNT_W(W)) dut (
    .clk(clk), .rst(rst), .pwm_en(pwm_en), .period(period),
    .duty_a(duty_a), .duty_b(duty_b), .fault_in(fault_in),
    .flt_irq_en(flt_irq_en), .flt_irq_clr(flt_irq_clr),
    .restart_ctl(restart_ctl), .per_irq_en(per_irq_en),
    .per_irq_clr(per_irq_clr), .pwm_a(pwm_a), .pwm_b(pwm_b),
    .flt_irq(flt_irq), .per_irq(per_irq));

  // Behavioural reference model
  int  m_cnt;
  bit  m_a, m_b, m_flt, m_per;
  bit  m_lock, m_wait;   // latched off / released but waiting for period start
  bit  fq[$];            // fault samples in flight
  bit  rq[$];            // restart samples in flight

  always @(posedge clk) begin
    bit fs, rel;
    if (rst) begin
      m_cnt = 0; m_a = 0; m_b = 0; m_flt = 0; m_per = 0;
      m_lock = 0; m_wait = 0;
      fq = '{0, 0}; rq = '{0, 0};
    end else begin
      fs  = fq[0];
      rel = rq[1] && !rq[0];
      m_a = pwm_en && (m_cnt < int'(duty_a));
      m_b = pwm_en && !fs && !m_lock && !m_wait && (m_cnt < int'(duty_b));
      if (fs && flt_irq_en) m_flt = 1; else if (flt_irq_clr) m_flt = 0;
      if (per_irq_en && m_cnt == 0) m_per = 1; else if (per_irq_clr) m_per = 0;
      if (!pwm_en) begin
        m_lock = 0; m_wait = 0;
      end else if (fs) begin
        m_lock = 1; m_wait = 0;
      end else if (m_lock && rel) begin
        m_lock = 0; m_wait = 1;
      end else if (m_wait && m_cnt >= int'(period)) begin
        m_wait = 0;
      end
      if (!pwm_en || m_cnt >= int'(period)) m_cnt = 0; else m_cnt++;
      void'(fq.pop_front()); fq.push_back(fault_in);
      void'(rq.pop_front()); rq.push_back(restart_ctl);
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // Per-cycle comparison against the model, away from the active edge
  always @(negedge clk) if (!done) begin
    chk(pwm_a   == m_a,   "R2/R8 pwm_a",  pwm_a,   m_a);
    chk(pwm_b   == m_b,   "R3/R7 pwm_b",  pwm_b,   m_b);
    chk(flt_irq == m_flt, "R9 flt_irq",   flt_irq, m_flt);
    chk(per_irq == m_per, "R11 per_irq",  per_irq, m_per);
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog: actual 0 expected 1 (test completion)");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int na, nb, seen;
    bit prev_a;
    step(4);
    // R1: reset state
    chk(!pwm_a && !pwm_b && !flt_irq && !per_irq, "R1 reset", {pwm_a,pwm_b,flt_irq,per_irq}, 0);
    rst = 0;
    step(1);
    chk(!pwm_a && !pwm_b, "R1 after reset", {pwm_a,pwm_b}, 0);

    // R2: steady run
    pwm_en = 1;
    step(25);
    na = 0; nb = 0;
    for (int i = 0; i < 10; i++) begin na += pwm_a; nb += pwm_b; step(1); end
    chk(na == 4, "R2 duty A", na, 4);
    chk(nb == 6, "R2 duty B", nb, 6);

    // R3: fault with interrupt disabled still shuts B
    restart_ctl = 1;        // level raised during normal run, held through the fault
    step(3);
    fault_in = 1;
    step(3);
    chk(pwm_b == 0, "R3 B off", pwm_b, 0);
    chk(flt_irq == 0, "R9 no irq when disabled", flt_irq, 0);
    step(4);
    fault_in = 0;
    // R4/R5: fault gone, held restart level does nothing
    seen = 0; na = 0;
    for (int i = 0; i < 30; i++) begin seen += pwm_b; na += pwm_a; step(1); end
    chk(seen == 0, "R4/R5 B stays latched", seen, 0);
    chk(na == 12, "R8 A keeps running", na, 12);

    // R9: fault with interrupt enabled, sticky, W1C
    flt_irq_en = 1;
    fault_in = 1;
    step(4);
    chk(flt_irq == 1, "R9 flag set", flt_irq, 1);
    fault_in = 0;
    step(5);
    chk(flt_irq == 1, "R9 flag sticky", flt_irq, 1);
    flt_irq_clr = 1; step(1); flt_irq_clr = 0; step(1);
    chk(flt_irq == 0, "R9 flag cleared", flt_irq, 0);

    // R6: restart edge while fault still present
    restart_ctl = 0; step(3);
    fault_in = 1; step(4);
    restart_ctl = 1; step(3);
    fault_in = 0;
    seen = 0;
    for (int i = 0; i < 25; i++) begin seen += pwm_b; step(1); end
    chk(seen == 0, "R6 restart ignored under fault", seen, 0);

    // R7: clean rising edge releases B at the next period start
    restart_ctl = 0; step(3);
    restart_ctl = 1;
    seen = 0; prev_a = pwm_a;
    for (int i = 0; i < 40 && !seen; i++) begin
      step(1);
      if (pwm_b) begin
        seen = 1;
        chk(pwm_a && !prev_a, "R7 B aligned to period start", {prev_a, pwm_a}, 1);
      end
      prev_a = pwm_a;
    end
    chk(seen == 1, "R5/R7 restart released B", seen, 1);
    restart_ctl = 0;
    step(12);

    // R10: disable/enable clears the latch
    fault_in = 1; step(4); fault_in = 0; step(4);
    pwm_en = 0; step(3);
    chk(!pwm_a && !pwm_b, "R10 outputs low when disabled", {pwm_a,pwm_b}, 0);
    pwm_en = 1;
    seen = 0;
    for (int i = 0; i < 12; i++) begin seen |= pwm_b; step(1); end
    chk(seen == 1, "R10 B runs after re-enable", seen, 1);

    // R11: period flag sets at boundary; stuck while disabled
    per_irq_en = 1; step(12);
    chk(per_irq == 1, "R11 period flag set", per_irq, 1);
    pwm_en = 0; step(3);
    per_irq_clr = 1; step(1); per_irq_clr = 0; step(1);
    chk(per_irq == 1, "R11 flag stuck while disabled", per_irq, 1);
    per_irq_en = 0; step(1);
    per_irq_clr = 1; step(1); per_irq_clr = 0; step(1);
    chk(per_irq == 0, "R11 flag clears with enable off", per_irq, 0);

    step(2);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule